// File: doc/BRIEF.md
# Multi-channel cell segmenting transmitter

This block takes frames from four independent input streams and merges them onto one outgoing 32-bit word stream that feeds a serial line encoder. Frames of any length are cut into cells of at most 128 payload words, which is 512 bytes. Every cell goes out as three parts in a row: one header word, the payload words, and one CRC-32 word. The link is handed to another channel only between cells. A long frame on one channel therefore delays traffic on another channel by at most one cell.

Each cell is first stored in an internal cell buffer and then sent. Because of this, the header can already state how many words the cell holds and whether it ends the frame. Channels are served in round-robin order. A channel whose pause input is high is not given a new cell. A cell that is already being filled or sent always runs to its CRC word.

Input side: each channel has its own `valid`/`ready` pair. A word moves on a rising clock edge when both are high. At most one `in_ready` bit is high at any time, and only while that channel's cell is being filled. A source must hold its word and markers stable until the word is accepted.

Output side: `out_valid`/`out_ready`. While `out_valid` is high and `out_ready` is low, the word and its flags stay unchanged.

Top module: `cell_mux_tx`

## Requirements
- R1: At most one `in_ready` bit is high in any cycle. It is high only for the channel whose cell is being filled, and only after that channel has been granted a new cell.
- R2: A cell carries at most 128 payload words. A frame of N words is sent as ceil(N/128) cells. Every cell except the frame's last one is full. Header bits [14:8] hold the cell's payload word count minus one.
- R3: A cell leaves as one uninterrupted group: a header word (`out_first`=1), its payload words, and a CRC word (`out_last`=1). No word of any other cell falls between them.
- R4: Payload words of one channel leave in the same order in which that channel accepted them, and unchanged.
- R5: The CRC word is CRC-32 with polynomial 0x04C11DB7. It starts from all ones, uses no reflection and no final inversion, and is computed MSB first over the header word and then each payload word.
- R6: A channel with `pause` high is never granted a new cell. If `pause` rises while that channel's cell is being filled or sent, the cell still completes through its CRC word, and the channel gets no further cell until `pause` falls.
- R7: When the link is free, the channel granted next is the first channel with a waiting word and `pause` low, searching upward (wrapping from 3 to 0) from the channel after the one granted last. After reset the search starts at channel 0.
- R8: Header layout: bits [1:0] channel number; bit 2 set if the cell's first word carried `in_sof`; bit 3 set if the cell ends the frame (its last word carried `in_eof`); bits [5:4] valid bytes in the cell's last word minus one, taken from `in_bytes` on an end-of-frame word and 3 otherwise. All other bits are zero.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data`, `out_first` and `out_last` hold their values.
- R10: After reset, `out_valid` and every `in_ready` bit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 4 | Per-channel word valid |
| in_ready | output | 4 | Per-channel word accept |
| in_data | input | 128 | Per-channel data word; channel c uses bits [32c+31:32c] |
| in_sof | input | 4 | Per-channel marker: word is the first of a frame |
| in_eof | input | 4 | Per-channel marker: word is the last of a frame |
| in_bytes | input | 8 | Per-channel valid bytes minus one on an end-of-frame word; channel c uses bits [2c+1:2c] |
| pause | input | 4 | Per-channel hold request from the link partner |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Header, payload or CRC word |
| out_first | output | 1 | Current word is a cell header |
| out_last | output | 1 | Current word is a cell CRC |

## Verification
The hardest situation to reach from the ports is a pause that rises while that channel's cell is still being filled, long before any of its words has left. The bench loads a 200-word frame on one channel and raises that channel's pause ten cycles later. It then requires the full 128-word cell and its CRC to come out, followed by a silent output for forty cycles. It then releases the pause and expects the remaining 72-word cell. A second case keeps two channels paused while the other two drain, so that round-robin order across four competing channels and the resumption after release are both compared word by word against the bench's own cell model.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTES_W = 2;
  localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {ST_IDLE, ST_FILL, ST_HDR, ST_PAY, ST_CRC} tx_state_e;

  // One 32-bit word folded into the running CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc32_word(input logic [WORD_W-1:0] c_in,
                                                   input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ d[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/cmx_rr_arb.sv
module cmx_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);
  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt_idx = last;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!gnt_any && req[idx]) begin
        gnt_any = 1'b1;
        gnt_idx = IDX_W'(idx);
      end
    end
  end

  // R7: a grant always names a requesting channel
  always_comb begin
    if (gnt_any) a_r7_grant_requests: assert (req[gnt_idx]);
  end
endmodule

// File: rtl/cmx_cell_buf.sv
module cmx_cell_buf #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];
endmodule

// File: rtl/cmx_crc_acc.sv
module cmx_crc_acc
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= '1;
    else if (en)     crc <= crc32_word(crc, din);
  end
endmodule

// File: rtl/cell_mux_tx.sv
module cell_mux_tx
  import cmx_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CELL_WORDS = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          in_valid,
  output logic [NUM_CH-1:0]          in_ready,
  input  logic [NUM_CH*WORD_W-1:0]   in_data,
  input  logic [NUM_CH-1:0]          in_sof,
  input  logic [NUM_CH-1:0]          in_eof,
  input  logic [NUM_CH*BYTES_W-1:0]  in_bytes,
  input  logic [NUM_CH-1:0]          pause,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_first,
  output logic                       out_last
);
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W = $clog2(CELL_WORDS);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CELL_WORDS - 1);

  tx_state_e          state;
  logic [CH_W-1:0]    cur_ch, last_ch, gnt_idx;
  logic               gnt_any;
  logic [CNT_W-1:0]   wr_cnt, rd_ptr, nwords;
  logic               cell_sof, cell_eof;
  logic [BYTES_W-1:0] cell_bytes;
  logic [WORD_W-1:0]  sel_data, rd_word, crc, hdr;
  logic [BYTES_W-1:0] sel_bytes;
  logic               fill_xfer, cell_done, out_xfer;

  assign sel_data  = in_data[cur_ch*WORD_W +: WORD_W];
  assign sel_bytes = in_bytes[cur_ch*BYTES_W +: BYTES_W];
  assign fill_xfer = (state == ST_FILL) && in_valid[cur_ch];
  assign cell_done = fill_xfer && (in_eof[cur_ch] || wr_cnt == CNT_MAX);
  assign in_ready  = (state == ST_FILL) ? (NUM_CH'(1) << cur_ch) : '0;
  assign out_valid = (state == ST_HDR) || (state == ST_PAY) || (state == ST_CRC);
  assign out_first = (state == ST_HDR);
  assign out_last  = (state == ST_CRC);
  assign out_xfer  = out_valid && out_ready;

  cmx_rr_arb #(.N(NUM_CH), .IDX_W(CH_W)) u_arb (
    .req(in_valid & ~pause), .last(last_ch), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  cmx_cell_buf #(.DEPTH(CELL_WORDS), .W(WORD_W)) u_buf (
    .clk(clk), .we(fill_xfer), .wa(wr_cnt), .wd(sel_data), .ra(rd_ptr), .rd(rd_word)
  );

  cmx_crc_acc u_crc (
    .clk(clk), .rst(rst), .init(cell_done), .en(out_xfer && state != ST_CRC),
    .din(out_data), .crc(crc)
  );

  always_comb begin
    hdr = '0;
    hdr[CH_W-1:0]    = cur_ch;
    hdr[2]           = cell_sof;
    hdr[3]           = cell_eof;
    hdr[5:4]         = cell_bytes;
    hdr[8 +: CNT_W]  = nwords;
  end

  always_comb begin
    case (state)
      ST_HDR:  out_data = hdr;
      ST_PAY:  out_data = rd_word;
      ST_CRC:  out_data = crc;
      default: out_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_ch     <= '0;
      last_ch    <= CH_W'(NUM_CH - 1);
      wr_cnt     <= '0;
      rd_ptr     <= '0;
      nwords     <= '0;
      cell_sof   <= 1'b0;
      cell_eof   <= 1'b0;
      cell_bytes <= '0;
    end else begin
      case (state)
        ST_IDLE: if (gnt_any) begin
          cur_ch  <= gnt_idx;
          last_ch <= gnt_idx;
          wr_cnt  <= '0;
          state   <= ST_FILL;
        end
        ST_FILL: if (fill_xfer) begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == '0) cell_sof <= in_sof[cur_ch];
          if (cell_done) begin
            cell_eof   <= in_eof[cur_ch];
            cell_bytes <= in_eof[cur_ch] ? sel_bytes : '1;
            nwords     <= wr_cnt;
            state      <= ST_HDR;
          end
        end
        ST_HDR: if (out_ready) begin
          rd_ptr <= '0;
          state  <= ST_PAY;
        end
        ST_PAY: if (out_ready) begin
          rd_ptr <= rd_ptr + 1'b1;
          if (rd_ptr == nwords) state <= ST_CRC;
        end
        ST_CRC: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: only one input channel may be accepting at a time
  a_r1_one_ready: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  // R3: a cell being filled keeps its owner until the cell is complete
  a_r3_owner_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL && !cell_done) |=> (state == ST_FILL && $stable(cur_ch)));

  // R5: the CRC word only ever follows the payload of its cell
  a_r5_crc_after_pay: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> ($past(state) == ST_PAY || $past(state) == ST_CRC));

  // R6: a paused channel is never handed a new cell
  a_r6_no_paused_grant: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && gnt_any) |-> !pause[gnt_idx]);

  // R9: a stalled output word holds still
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_first) && $stable(out_last)));
endmodule

// File: tb/cell_mux_tx_bench.sv
`timescale 1ns/1ps
module cell_mux_tx_bench;
  localparam int NC = 4;
  localparam int CW = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic [NC-1:0]  in_valid = '0, in_sof = '0, in_eof = '0, pause = '0;
  logic [NC*32-1:0] in_data = '0;
  logic [NC*2-1:0]  in_bytes = '0;
  logic [NC-1:0]  in_ready;
  logic           out_valid, out_first, out_last;
  logic           out_ready = 1'b0;
  logic [31:0]    out_data;

  cell_mux_tx u_cell_mux_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_bytes(in_bytes), .pause(pause),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  // word in a channel queue: [35] eof, [34] sof, [33:32] bytes-1, [31:0] data
  logic [35:0] chq [NC][$];
  // expected output word: [33:32] kind (0 header, 1 payload, 2 crc), [31:0] value
  logic [33:0] exp_q [$];
  int   checks = 0, fails = 0, mlast = NC - 1;
  logic run = 1'b0;
  logic [NC-1:0] in_xfer = '0;
  logic prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  logic prev_first = 1'b0, prev_last = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_w(input logic [31:0] c0, input logic [31:0] d);
    logic [31:0] c;
    logic fb;
    c = c0;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic add_frame(input int ch, input int n, input logic [1:0] b);
    for (int i = 0; i < n; i++) begin
      logic [35:0] w;
      w[31:0]  = $urandom;
      w[33:32] = (i == n - 1) ? b : 2'b00;
      w[34]    = (i == 0);
      w[35]    = (i == n - 1);
      chq[ch].push_back(w);
    end
  endtask

  // Behavioural cell model: round robin over non-paused channels with queued words
  function automatic void build(input logic [NC-1:0] pm);
    logic [35:0] mq [NC][$];
    logic [35:0] cellq [$];
    logic [31:0] c, hdr;
    logic [1:0]  b;
    int ch, n;
    for (int k = 0; k < NC; k++) mq[k] = chq[k];
    while (1) begin
      ch = -1;
      for (int k = 1; k <= NC; k++) begin
        int i;
        i = (mlast + k) % NC;
        if (ch < 0 && mq[i].size() > 0 && !pm[i]) ch = i;
      end
      if (ch < 0) break;
      cellq.delete();
      while (mq[ch].size() > 0 && cellq.size() < CW) begin
        cellq.push_back(mq[ch].pop_front());
        if (cellq[cellq.size()-1][35]) break;
      end
      n = cellq.size();
      b = cellq[n-1][35] ? cellq[n-1][33:32] : 2'b11;
      hdr = 32'(ch) | (32'(cellq[0][34]) << 2) | (32'(cellq[n-1][35]) << 3)
          | (32'(b) << 4) | (32'(n - 1) << 8);
      exp_q.push_back({2'd0, hdr});
      c = crc_w(32'hFFFF_FFFF, hdr);
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({2'd1, cellq[i][31:0]});
        c = crc_w(c, cellq[i][31:0]);
      end
      exp_q.push_back({2'd2, c});
      mlast = ch;
    end
  endfunction

  // Driver and per-clock comparison, all away from the rising edge
  always @(negedge clk) begin
    if (run) begin
      for (int c = 0; c < NC; c++) if (in_xfer[c]) void'(chq[c].pop_front());
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_first == prev_first
              && out_last == prev_last, "R9 stalled word held", out_data, prev_data);
      for (int c = 0; c < NC; c++) begin
        if (chq[c].size() > 0) begin
          in_valid[c]          = 1'b1;
          in_data[c*32 +: 32]  = chq[c][0][31:0];
          in_bytes[c*2 +: 2]   = chq[c][0][33:32];
          in_sof[c]            = chq[c][0][34];
          in_eof[c]            = chq[c][0][35];
        end else begin
          in_valid[c] = 1'b0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      in_xfer = in_valid & in_ready;
      check($onehot0(in_ready), "R1 single ready", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", out_data, 32'd0);
        end else begin
          logic [33:0] e;
          e = exp_q.pop_front();
          case (e[33:32])
            2'd0: check(out_data == e[31:0] && out_first && !out_last,
                        "R2 R7 R8 header", out_data, e[31:0]);
            2'd1: check(out_data == e[31:0] && !out_first && !out_last,
                        "R3 R4 payload", out_data, e[31:0]);
            default: check(out_data == e[31:0] && out_last && !out_first,
                        "R5 crc", out_data, e[31:0]);
          endcase
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_first = out_first;
      prev_last  = out_last;
    end
  end

  task automatic wait_drain(input int limit);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(posedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R3 drain watchdog", 32'(exp_q.size()), 32'd0);
    repeat (6) @(posedge clk);
  endtask

  initial begin
    #1_800_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    // R10: idle after reset
    check(!out_valid, "R10 out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == '0, "R10 in_ready after reset", 32'(in_ready), 32'd0);
    run = 1'b1;

    // short frame, partial last word with 3 valid bytes (R8 bytes field)
    add_frame(0, 5, 2'd2);
    build('0);
    wait_drain(2000);

    // R2 R7: competing channels, exact-cell, one-over and long frames
    add_frame(1, 128, 2'd3);
    add_frame(2, 129, 2'd0);
    add_frame(3, 1, 2'd1);
    add_frame(0, 300, 2'd3);
    build('0);
    wait_drain(20000);

    // R6: two channels paused while the others drain
    pause = 4'b1010;
    for (int c = 0; c < NC; c++) add_frame(c, 40 + 30 * c, 2'(c));
    build(4'b1010);
    wait_drain(20000);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #2;
      check(!out_valid, "R6 paused channels stay silent", 32'(out_valid), 32'd0);
    end
    check(chq[1].size() == 70 && chq[3].size() == 130, "R6 paused words untouched",
          32'(chq[1].size() + chq[3].size()), 32'd200);
    pause = '0;
    build('0);
    wait_drain(20000);

    // R6: pause rising while the channel's cell is still filling
    add_frame(2, 200, 2'd3);
    build('0);
    repeat (10) @(posedge clk);
    #2 pause[2] = 1'b1;
    begin
      int n;
      n = 0;
      while (exp_q.size() > 74 && n < 5000) begin
        @(posedge clk);
        n++;
      end
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      check(!out_valid, "R6 no cell after mid-cell pause", 32'(out_valid), 32'd0);
    end
    check(exp_q.size() == 74, "R6 first cell completed whole", 32'(exp_q.size()), 32'd74);
    #1 pause[2] = 1'b0;
    wait_drain(5000);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule